// File: doc/BRIEF.md
# Edge capture channel

This block watches one external input line and either counts its edges or timestamps them. The line first passes through a two-flop synchronizer. An edge detector then decides which transitions count, according to a programmable polarity: rising only, falling only, or both. A small controller handles the rest. In counting mode, arming loads a 24-bit start value, and each qualifying edge takes one from it. When the value reaches a programmed target, the channel pulses a match strobe and halts. In timestamp mode, a free-running 24-bit cycle counter is copied into the result register on every qualifying edge, and an event strobe pulses.

The 24-bit quantity is built from a 16-bit low part and an 8-bit extension that acts as its top byte. The result is presented zero-extended on a 32-bit output.

The controller has four states. ST_OFF is idle. ST_COUNT counts edges down. ST_TIME timestamps edges. ST_HALT is the stopped state after a match. Its transitions are:
- arm-count: ST_OFF to ST_COUNT, when enable is high and the mode bit is 0.
- arm-time: ST_OFF to ST_TIME, when enable is high and the mode bit is 1.
- hit: ST_COUNT to ST_HALT, on a qualifying edge whose decremented value equals the target.
- disarm: any state to ST_OFF, whenever enable is low.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, `value_o` is 0 and both `evt_o` and `match_o` are low.
- R2: When enable rises with `time_mode_i`=0, the value {`load_pre_i`,`load_val_i`} appears on `value_o` one clock later.
- R3: `edge_sel_i` picks which edges qualify: 0 selects rising, 1 selects falling, 3 selects both, and 2 selects none.
- R4: In counting mode, each qualifying edge lowers `value_o` by exactly one. The change is visible three clocks after the pin changes: two synchronizer stages plus the detection stage.
- R5: When a decrement yields {`match_pre_i`,`match_val_i`}, `match_o` is high for exactly one cycle and the channel halts. Later edges leave `value_o` unchanged until enable goes low and then high again, which reloads the start value.
- R6: A 24-bit counter increments on every clock after reset. In timestamp mode, a qualifying edge copies into `value_o` the count held before the clock edge on which the edge is acted on, and `evt_o` is high for exactly that one cycle.
- R7: While enable is low, no pulse is raised and `value_o` holds, whatever the pin does.
- R8: `value_o[15:0]` is the low part of the count and `value_o[23:16]` is its extension byte. A borrow out of the low part decrements the extension byte. `value_o[31:24]` is always zero.
- R9: `evt_o` is raised only in timestamp mode and `match_o` only in counting mode.
- R10: When enable rises with `time_mode_i`=1, `value_o` is cleared to zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Channel enable; low returns the channel to ST_OFF |
| time_mode_i | input | 1 | 0 selects edge counting, 1 selects timestamping; sampled on arming |
| edge_sel_i | input | 2 | Edge polarity: 0 rising, 1 falling, 2 none, 3 both |
| load_val_i | input | 16 | Low part of the start value for counting |
| load_pre_i | input | 8 | Extension byte of the start value |
| match_val_i | input | 16 | Low part of the target value |
| match_pre_i | input | 8 | Extension byte of the target value |
| pin_i | input | 1 | Asynchronous external input line |
| evt_o | output | 1 | One-cycle strobe when a timestamp is taken |
| match_o | output | 1 | One-cycle strobe when the count reaches the target |
| value_o | output | 32 | Count or timestamp, zero-extended from 24 bits |

## Verification
The embedded properties watch every cycle for the following:
- the step of exactly one per counted edge;
- the value held throughout ST_HALT;
- silence while disabled or with the reserved polarity code;
- each strobe appearing only from its own mode's state, with the match strobe carrying the target value.

Only the bench scenarios can show the rest:
- that the right polarity is chosen for each code across sweeps of all four codes;
- that the three-cycle synchronizer latency holds;
- that timestamps equal the absolute cycle number the bench predicts;
- that a borrow crosses into the extension byte;
- that re-arming reloads the start value.

// File: rtl/ecap_pkg.sv
`timescale 1ns/1ps
package ecap_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_COUNT = 2'd1,
        ST_TIME  = 2'd2,
        ST_HALT  = 2'd3
    } ecap_state_e;

    localparam logic [1:0] EDGE_RISE = 2'd0;
    localparam logic [1:0] EDGE_FALL = 2'd1;
    localparam logic [1:0] EDGE_NONE = 2'd2;
    localparam logic [1:0] EDGE_BOTH = 2'd3;

endpackage

// File: rtl/ecap_edge_detect.sv
`timescale 1ns/1ps
module ecap_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] edge_sel_i,
    output logic       qual_o
);
    import ecap_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   lvl;
    logic                   rise;
    logic                   fall;

    // Synchronizer chain followed by a one-cycle history flop.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign lvl  = sync_q[SYNC_STAGES-1];
    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    always_comb begin
        unique case (edge_sel_i)
            EDGE_RISE: qual_o = rise;
            EDGE_FALL: qual_o = fall;
            EDGE_BOTH: qual_o = rise | fall;
            default:   qual_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ecap_datapath.sv
`timescale 1ns/1ps
module ecap_datapath #(
    parameter int LOW_W = 16,
    parameter int PRE_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic                   clear_i,
    input  logic                   dec_i,
    input  logic                   latch_i,
    input  logic [LOW_W-1:0]       load_val_i,
    input  logic [PRE_W-1:0]       load_pre_i,
    input  logic [LOW_W-1:0]       match_val_i,
    input  logic [PRE_W-1:0]       match_pre_i,
    output logic                   hit_o,
    output logic [LOW_W+PRE_W-1:0] val_o
);
    localparam int CNT_W = LOW_W + PRE_W;

    logic [CNT_W-1:0] free_q;
    logic [CNT_W-1:0] val_q;
    logic [CNT_W-1:0] val_dec;

    assign val_dec = val_q - CNT_W'(1);

    // Free-running timebase, active from reset release.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) free_q <= '0;
        else        free_q <= free_q + CNT_W'(1);
    end

    // Shared result register: count in one mode, timestamp in the other.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       val_q <= '0;
        else if (clear_i) val_q <= '0;
        else if (load_i)  val_q <= {load_pre_i, load_val_i};
        else if (dec_i)   val_q <= val_dec;
        else if (latch_i) val_q <= free_q;
    end

    assign hit_o = (val_dec == {match_pre_i, match_val_i});
    assign val_o = val_q;

    // R6: a latch strobe copies the timebase as it stood before the edge.
    assert_time_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        latch_i && !clear_i && !load_i && !dec_i |=> val_q == $past(free_q));

endmodule

// File: rtl/ecap_fsm.sv
`timescale 1ns/1ps
module ecap_fsm (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable_i,
    input  logic                 time_mode_i,
    input  logic                 qual_i,
    input  logic                 hit_i,
    output ecap_pkg::ecap_state_e state_o,
    output logic                 load_o,
    output logic                 clear_o,
    output logic                 dec_o,
    output logic                 latch_o,
    output logic                 evt_o,
    output logic                 match_o
);
    import ecap_pkg::*;

    ecap_state_e state_q;
    ecap_state_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Transitions: arm-count, arm-time, hit, disarm.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (enable_i) state_d = time_mode_i ? ST_TIME : ST_COUNT;
            ST_COUNT: if (!enable_i) state_d = ST_OFF;
                      else if (qual_i && hit_i) state_d = ST_HALT;
            ST_TIME:  if (!enable_i) state_d = ST_OFF;
            ST_HALT:  if (!enable_i) state_d = ST_OFF;
            default:  state_d = ST_OFF;
        endcase
    end

    // Datapath strobes.
    always_comb begin
        load_o  = (state_q == ST_OFF)   && enable_i && !time_mode_i;
        clear_o = (state_q == ST_OFF)   && enable_i &&  time_mode_i;
        dec_o   = (state_q == ST_COUNT) && enable_i && qual_i;
        latch_o = (state_q == ST_TIME)  && enable_i && qual_i;
    end

    // Registered one-cycle status strobes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_o   <= 1'b0;
            match_o <= 1'b0;
        end else begin
            evt_o   <= latch_o;
            match_o <= dec_o && hit_i;
        end
    end

    assign state_o = state_q;

    assert_evt_from_time_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> $past(state_q == ST_TIME));
    assert_match_from_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(state_q == ST_COUNT));
    assert_match_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match_o && $past(enable_i) |-> state_q == ST_HALT);

endmodule

// File: rtl/edge_capture_unit.sv
`timescale 1ns/1ps
module edge_capture_unit #(
    parameter int SYNC_STAGES = 2,
    parameter int LOW_W       = 16,
    parameter int PRE_W       = 8,
    parameter int OUT_W       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             time_mode_i,
    input  logic [1:0]       edge_sel_i,
    input  logic [LOW_W-1:0] load_val_i,
    input  logic [PRE_W-1:0] load_pre_i,
    input  logic [LOW_W-1:0] match_val_i,
    input  logic [PRE_W-1:0] match_pre_i,
    input  logic             pin_i,
    output logic             evt_o,
    output logic             match_o,
    output logic [OUT_W-1:0] value_o
);
    import ecap_pkg::*;

    localparam int CNT_W = LOW_W + PRE_W;

    logic             qual;
    logic             hit;
    logic             load_s;
    logic             clear_s;
    logic             dec_s;
    logic             latch_s;
    logic [CNT_W-1:0] cnt_val;
    ecap_state_e      state;

    ecap_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pin_i),
        .edge_sel_i (edge_sel_i),
        .qual_o     (qual)
    );

    ecap_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (enable_i),
        .time_mode_i (time_mode_i),
        .qual_i      (qual),
        .hit_i       (hit),
        .state_o     (state),
        .load_o      (load_s),
        .clear_o     (clear_s),
        .dec_o       (dec_s),
        .latch_o     (latch_s),
        .evt_o       (evt_o),
        .match_o     (match_o)
    );

    ecap_datapath #(.LOW_W(LOW_W), .PRE_W(PRE_W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_s),
        .clear_i     (clear_s),
        .dec_i       (dec_s),
        .latch_i     (latch_s),
        .load_val_i  (load_val_i),
        .load_pre_i  (load_pre_i),
        .match_val_i (match_val_i),
        .match_pre_i (match_pre_i),
        .hit_o       (hit),
        .val_o       (cnt_val)
    );

    assign value_o = OUT_W'(cnt_val);

    assert_off_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !evt_o && !match_o && $stable(cnt_val));
    assert_reserved_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_sel_i == EDGE_NONE |=> !evt_o && !match_o);
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_COUNT && enable_i && qual |=> cnt_val == CNT_W'($past(cnt_val) - CNT_W'(1)));
    assert_halt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_HALT |=> $stable(cnt_val));
    assert_match_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> cnt_val == $past({match_pre_i, match_val_i}));

endmodule

// File: tb/edge_capture_unit_tb.sv
`timescale 1ns/1ps
module edge_capture_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0;
    logic        time_mode_i = 1'b0;
    logic [1:0]  edge_sel_i = 2'd0;
    logic [15:0] load_val_i = 16'd0;
    logic [7:0]  load_pre_i = 8'd0;
    logic [15:0] match_val_i = 16'd0;
    logic [7:0]  match_pre_i = 8'd0;
    logic        pin_i = 1'b0;
    logic        evt_o;
    logic        match_o;
    logic [31:0] value_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    edge_capture_unit u_dut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .time_mode_i(time_mode_i),
        .edge_sel_i(edge_sel_i), .load_val_i(load_val_i), .load_pre_i(load_pre_i),
        .match_val_i(match_val_i), .match_pre_i(match_pre_i), .pin_i(pin_i),
        .evt_o(evt_o), .match_o(match_o), .value_o(value_o)
    );

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc = cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Toggle the pin at a falling clock edge, then wait to the sample point
    // three rising edges later. Returns the bench cycle count at the toggle.
    task automatic flip_pin(output int t_cyc);
        @(negedge clk);
        pin_i = ~pin_i;
        t_cyc = cyc;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic arm(input logic [1:0] sel, input logic tmode);
        @(negedge clk);
        enable_i = 1'b0;
        @(negedge clk);
        edge_sel_i  = sel;
        time_mode_i = tmode;
        enable_i    = 1'b1;
        @(negedge clk);
    endtask

    function automatic bit qualifies(input logic [1:0] sel, input logic new_lvl);
        return (sel == 2'd0 && new_lvl) || (sel == 2'd1 && !new_lvl) || (sel == 2'd3);
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int          t;
        logic [23:0] expv;
        logic [31:0] held;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 value", value_o, 32'd0);
        check("R1 evt", {31'd0, evt_o}, 32'd0);
        check("R1 match", {31'd0, match_o}, 32'd0);

        // Counting sweep over every polarity code; start value crosses a byte borrow.
        load_pre_i = 8'h05; load_val_i = 16'h0002;
        match_pre_i = 8'h00; match_val_i = 16'h0000;
        for (int sel = 0; sel < 4; sel++) begin
            arm(2'(sel), 1'b0);
            expv = 24'h050002;
            check("R2 load", value_o, {8'd0, expv});
            for (int k = 0; k < 6; k++) begin
                flip_pin(t);
                if (qualifies(2'(sel), pin_i)) expv = expv - 24'd1;
                check("R3/R4/R8 count", value_o, {8'd0, expv});
                check("R9 no evt in count", {31'd0, evt_o}, 32'd0);
                check("R5 no early match", {31'd0, match_o}, 32'd0);
            end
        end

        // Timestamp sweep over every polarity code with varied spacing.
        for (int sel = 0; sel < 4; sel++) begin
            arm(2'(sel), 1'b1);
            check("R10 clear", value_o, 32'd0);
            expv = 24'd0;
            for (int k = 0; k < 5; k++) begin
                repeat (k * 3 + sel) @(negedge clk);
                flip_pin(t);
                if (qualifies(2'(sel), pin_i)) begin
                    expv = 24'(t + 2);
                    check("R6 evt", {31'd0, evt_o}, 32'd1);
                end else begin
                    check("R3 no evt", {31'd0, evt_o}, 32'd0);
                end
                check("R6 stamp", value_o, {8'd0, expv});
                check("R9 no match in time", {31'd0, match_o}, 32'd0);
                @(negedge clk);
                check("R6 one-cycle evt", {31'd0, evt_o}, 32'd0);
            end
        end

        // Disabled: pin activity is ignored.
        @(negedge clk);
        enable_i = 1'b0;
        @(negedge clk);
        held = value_o;
        for (int k = 0; k < 4; k++) begin
            flip_pin(t);
            check("R7 hold", value_o, held);
            check("R7 quiet", {30'd0, evt_o, match_o}, 32'd0);
        end

        // Match and halt.
        pin_i = 1'b0;
        repeat (4) @(negedge clk);
        load_pre_i = 8'h00; load_val_i = 16'd3;
        match_pre_i = 8'h00; match_val_i = 16'd1;
        arm(2'd0, 1'b0);
        check("R2 load small", value_o, 32'd3);
        flip_pin(t);
        check("R4 step", value_o, 32'd2);
        flip_pin(t);
        flip_pin(t);
        check("R5 reach", value_o, 32'd1);
        check("R5 match pulse", {31'd0, match_o}, 32'd1);
        @(negedge clk);
        check("R5 one-cycle match", {31'd0, match_o}, 32'd0);
        flip_pin(t);
        flip_pin(t);
        check("R5 halted hold", value_o, 32'd1);
        check("R5 no second match", {31'd0, match_o}, 32'd0);
        arm(2'd0, 1'b0);
        check("R5 rearm reload", value_o, 32'd3);

        // Borrow from the low part into the extension byte, ending on a match.
        load_pre_i = 8'h01; load_val_i = 16'h0001;
        match_pre_i = 8'h00; match_val_i = 16'hFFFF;
        arm(2'd3, 1'b0);
        flip_pin(t);
        check("R8 low zero", value_o, 32'h0001_0000);
        flip_pin(t);
        check("R8 borrow", value_o, 32'h0000_FFFF);
        check("R5 match at borrow", {31'd0, match_o}, 32'd1);

        finish_run();
    end

endmodule